// File: doc/BRIEF.md
# Tagged Transmit FIFO with Frame Tracking

This block buffers outgoing words between a host and a network peripheral. The host writes words through a data port on a simple register write bus. A consumer pops those words in order. Each stored word carries two side bits. One marks the word as control information and the other marks it as the last word of a frame. The host arms each side bit with a one-shot bit in the control register, and that bit clears itself on the next data write.

The block counts the complete frames it holds and derives a frame-ready flag from that count. It also drives a registered service alarm from the free space. Outside frame mode the alarm has hysteresis: it sets at a programmable level and clears at a lower point set by a granularity field. In frame mode the hysteresis is dropped and the frame-ready flag becomes the frame request. An optional timer mode holds frame requests back and issues them only as periodic pulses.

The register bus uses four addresses: 0 is control, 1 is alarm configuration, 2 is the data port and 3 clears the sticky flags (write 1 to clear).

Top module: `tagged_tx_fifo`

## Requirements
- R1: Words written to address 2 are popped in the order they were written, with the 32 data bits intact. `pop_data`/`pop_ctl`/`pop_eof` show the oldest word while `empty` is 0. `fill` gives the number of words held, up to 64.
- R2: Writing control (address 0) with bit 30 set makes the next data word carry `pop_ctl`=1. That write clears the bit, so the following words carry `pop_ctl`=0.
- R3: Writing control with bit 29 and bit 27 (frame mode) both set makes the next data word carry `pop_eof`=1, and the bit then clears itself. If bit 27 is clear in that same control write, bit 29 has no effect.
- R4: `frame_count` rises by one when an end-of-frame word is stored and falls by one when one is popped. `frame_ready` is 1 exactly when frame mode (bit 27) is set and `frame_count` is non-zero.
- R5: A write to the data port while 64 words are held is dropped and sets the sticky `overflow` flag. The stored words are not changed. Writing address 3 with bit 0 set clears the flag.
- R6: A pop while the FIFO is empty sets the sticky `underflow` flag and leaves `fill` at 0. Writing address 3 with bit 1 set clears the flag.
- R7: Outside frame mode, `alarm` sets one cycle after the free space (64 − `fill`) is at least the level in bits 6:0 of address 1. Once set, it clears only one cycle after the free space is below level − 4×G, where G is bits 10:8 of address 1.
- R8: In frame mode `alarm` has no hysteresis. One cycle after any change, it equals (free space ≥ level).
- R9: With frame mode and timer mode (bit 28) both set, `frame_req` is a one-cycle pulse. It fires every N×64 cycles while at least one frame is held, where N is bits 15:0 of control. Every data-port write or pop restarts the period. With timer mode clear, `frame_req` equals `frame_ready`.
- R10: After reset the FIFO is empty and every flag and count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register bus write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 alarm config, 2 data, 3 clear) |
| wr_data | input | 32 | Register write data |
| pop | input | 1 | Consumer pop request |
| pop_data | output | 32 | Data of the oldest word |
| pop_ctl | output | 1 | Control tag of the oldest word |
| pop_eof | output | 1 | End-of-frame tag of the oldest word |
| empty | output | 1 | No words held |
| fill | output | 7 | Number of words held |
| frame_count | output | 7 | Complete frames held |
| frame_ready | output | 1 | At least one frame held, frame mode on |
| frame_req | output | 1 | Frame service request (pulsed in timer mode) |
| alarm | output | 1 | Level-based service alarm |
| overflow | output | 1 | Sticky: write to a full FIFO |
| underflow | output | 1 | Sticky: pop from an empty FIFO |

## Verification
The bench fills the FIFO to exactly 64 words and writes one more. A design that accepted that word would either overwrite the oldest entry or push the scoreboard's expected sequence out of step. The bench walks the free space across the set and clear points in both directions, and a design without hysteresis, or with the clear point off by one, would toggle the alarm at the wrong count. It also checks that a one-shot tag lands only on the very next word, and that an end-of-frame tag armed without frame mode is discarded. Finally it measures the timer pulse spacing exactly, so a design whose period is off by a cycle, or that gives a level rather than a pulse, is caught.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int DW = 32;

  // control register bit positions, decoded by the register block
  localparam int B_CTL = 30;
  localparam int B_EOF = 29;
  localparam int B_TMR = 28;
  localparam int B_FRM = 27;

  // alarm configuration field positions
  localparam int LVL_LSB  = 0;
  localparam int GRAN_LSB = 8;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_ALARM = 2'd1,
    A_DATA  = 2'd2,
    A_CLEAR = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic          ctl;
    logic          eof;
    logic [DW-1:0] data;
  } fifo_word_t;
endpackage

// File: rtl/tfifo_regs.sv
module tfifo_regs
  import tfifo_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int GRAN_W    = 3,
  parameter int TMR_W     = 16,
  parameter int DEF_LEVEL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              push,
  output fifo_word_t        push_word,
  output logic              frm_en,
  output logic              tmr_en,
  output logic [TMR_W-1:0]  tmr_period,
  output logic [CNT_W-1:0]  alarm_level,
  output logic [GRAN_W-1:0] gran,
  output logic              clr_ovf,
  output logic              clr_unf
);
  logic              ctl_tag_q, ctl_tag_d;
  logic              eof_tag_q, eof_tag_d;
  logic              frm_q, frm_d;
  logic              tmr_q, tmr_d;
  logic [TMR_W-1:0]  per_q, per_d;
  logic [CNT_W-1:0]  lvl_q, lvl_d;
  logic [GRAN_W-1:0] gran_q, gran_d;
  logic              wr_ctrl, wr_alarm, wr_clear;
  logic              unused_parity;

  assign unused_parity = ^wr_data;

  always_comb begin
    wr_ctrl  = wr_valid && (wr_addr == A_CTRL);
    wr_alarm = wr_valid && (wr_addr == A_ALARM);
    push     = wr_valid && (wr_addr == A_DATA);
    wr_clear = wr_valid && (wr_addr == A_CLEAR);
  end

  always_comb begin
    ctl_tag_d = ctl_tag_q;
    eof_tag_d = eof_tag_q;
    frm_d     = frm_q;
    tmr_d     = tmr_q;
    per_d     = per_q;
    lvl_d     = lvl_q;
    gran_d    = gran_q;
    if (wr_ctrl) begin
      ctl_tag_d = wr_data[B_CTL];
      eof_tag_d = wr_data[B_EOF] & wr_data[B_FRM];
      frm_d     = wr_data[B_FRM];
      tmr_d     = wr_data[B_TMR];
      per_d     = wr_data[TMR_W-1:0];
    end
    if (wr_alarm) begin
      lvl_d  = wr_data[LVL_LSB +: CNT_W];
      gran_d = wr_data[GRAN_LSB +: GRAN_W];
    end
    if (push) begin
      ctl_tag_d = 1'b0;
      eof_tag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_tag_q <= 1'b0;
      eof_tag_q <= 1'b0;
      frm_q     <= 1'b0;
      tmr_q     <= 1'b0;
      per_q     <= '0;
      lvl_q     <= CNT_W'(DEF_LEVEL);
      gran_q    <= '0;
    end else begin
      ctl_tag_q <= ctl_tag_d;
      eof_tag_q <= eof_tag_d;
      frm_q     <= frm_d;
      tmr_q     <= tmr_d;
      per_q     <= per_d;
      lvl_q     <= lvl_d;
      gran_q    <= gran_d;
    end
  end

  always_comb begin
    push_word.ctl  = ctl_tag_q;
    push_word.eof  = eof_tag_q;
    push_word.data = wr_data;
    frm_en      = frm_q;
    tmr_en      = tmr_q;
    tmr_period  = per_q;
    alarm_level = lvl_q;
    gran        = gran_q;
    clr_ovf     = wr_clear & wr_data[0];
    clr_unf     = wr_clear & wr_data[1];
  end

  // R2: a data write consumes the one-shot control tag
  p_ctl_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !ctl_tag_q);
  // R3: an armed end-of-frame tag only exists in frame mode
  p_eof_needs_frm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eof_tag_q |-> frm_q);
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  fifo_word_t       push_word,
  input  logic             pop,
  input  logic             clr_ovf,
  input  logic             clr_unf,
  output fifo_word_t       head,
  output logic [CNT_W-1:0] fill,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf,
  output logic             unf
);
  localparam int PTR_W = $clog2(DEPTH);

  fifo_word_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             full;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (fill_q == CNT_W'(DEPTH));
    empty   = (fill_q == '0);
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    wr_ptr_d = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    fill_d   = fill_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    ovf_d    = (ovf_q & ~clr_ovf) | (push & full);
    unf_d    = (unf_q & ~clr_unf) | (pop & empty);
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr_q] <= push_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
      ovf_q    <= ovf_d;
      unf_q    <= unf_d;
    end
  end

  assign head = mem[rd_ptr_q];
  assign fill = fill_q;
  assign ovf  = ovf_q;
  assign unf  = unf_q;

  // R5: occupancy never exceeds the depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
  // R5: a write into a full store is dropped and flagged
  p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(fill_q) && ovf_q));
  // R6: a pop from an empty store is flagged and changes nothing
  p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (unf_q && fill_q == '0));
endmodule

// File: rtl/tfifo_frame.sv
module tfifo_frame #(
  parameter int CNT_W   = 7,
  parameter int TMR_W   = 16,
  parameter int TICK_SH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic             push_eof,
  input  logic             pop_ok,
  input  logic             head_eof,
  input  logic             access,
  input  logic             frm_en,
  input  logic             tmr_en,
  input  logic [TMR_W-1:0] period,
  input  logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] frame_count,
  output logic             frame_ready,
  output logic             frame_req
);
  localparam int TW = TMR_W + TICK_SH;

  logic [CNT_W-1:0] frm_q, frm_d;
  logic [TW-1:0]    tmr_q, tmr_d, limit;
  logic             pulse_q, pulse_d;
  logic             active;

  always_comb begin
    frm_d = frm_q + CNT_W'(push_ok & push_eof) - CNT_W'(pop_ok & head_eof);
  end

  always_comb begin
    active  = frm_en & tmr_en;
    limit   = {period, {TICK_SH{1'b0}}};
    tmr_d   = tmr_q;
    pulse_d = 1'b0;
    if (!active || access || period == '0) begin
      tmr_d = '0;
    end else if (tmr_q == limit - 1'b1) begin
      tmr_d   = '0;
      pulse_d = (frm_q != '0);
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q   <= '0;
      tmr_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      frm_q   <= frm_d;
      tmr_q   <= tmr_d;
      pulse_q <= pulse_d;
    end
  end

  assign frame_count = frm_q;
  assign frame_ready = frm_en && (frm_q != '0);
  assign frame_req   = active ? pulse_q : frame_ready;

  // R4: complete frames never outnumber held words
  p_frames_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q <= fill);
  // R9: the timed request lasts a single cycle
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R9: a timed request needs a held frame
  p_req_has_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> ($past(frm_q) != '0));
endmodule

// File: rtl/tfifo_alarm.sv
module tfifo_alarm #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7,
  parameter int GRAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  fill,
  input  logic [CNT_W-1:0]  level,
  input  logic [GRAN_W-1:0] gran,
  input  logic              frm_en,
  output logic              alarm
);
  localparam int MW = CNT_W + GRAN_W + 2;

  logic [MW-1:0] free_w, lvl_w, g4_w, clr_pt;
  logic          borrow, reach, below;
  logic          alarm_q, alarm_d;

  always_comb begin
    free_w = MW'(DEPTH) - MW'(fill);
    lvl_w  = MW'(level);
    g4_w   = MW'({gran, 2'b00});
    borrow = lvl_w < g4_w;
    clr_pt = lvl_w - g4_w;
    reach  = free_w >= lvl_w;
    below  = !borrow && (free_w < clr_pt);
    if (frm_en)        alarm_d = reach;
    else if (!alarm_q) alarm_d = reach;
    else               alarm_d = !below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= alarm_d;
  end

  assign alarm = alarm_q;

  // R7: reaching the level always raises the alarm next cycle
  p_alarm_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_w >= lvl_w) |=> alarm_q);
  // R8: frame mode drops the alarm as soon as space is short
  p_frame_no_hyst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_en && free_w < lvl_w) |=> !alarm_q);
endmodule

// File: rtl/tagged_tx_fifo.sv
module tagged_tx_fifo
  import tfifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int GRAN_W    = 3,
  parameter int TMR_W     = 16,
  parameter int TICK_SH   = 6,
  parameter int DEF_LEVEL = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [1:0]               wr_addr,
  input  logic [31:0]              wr_data,
  input  logic                     pop,
  output logic [31:0]              pop_data,
  output logic                     pop_ctl,
  output logic                     pop_eof,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   fill,
  output logic [$clog2(DEPTH):0]   frame_count,
  output logic                     frame_ready,
  output logic                     frame_req,
  output logic                     alarm,
  output logic                     overflow,
  output logic                     underflow
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifo_word_t        push_word, head;
  logic              push, push_ok, pop_ok;
  logic              frm_en, tmr_en, clr_ovf, clr_unf;
  logic [TMR_W-1:0]  tmr_period;
  logic [CNT_W-1:0]  alarm_level, fill_w;
  logic [GRAN_W-1:0] gran;

  tfifo_regs #(
    .CNT_W(CNT_W), .GRAN_W(GRAN_W), .TMR_W(TMR_W), .DEF_LEVEL(DEF_LEVEL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .push(push), .push_word(push_word), .frm_en(frm_en),
    .tmr_en(tmr_en), .tmr_period(tmr_period), .alarm_level(alarm_level),
    .gran(gran), .clr_ovf(clr_ovf), .clr_unf(clr_unf)
  );

  tfifo_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word), .pop(pop),
    .clr_ovf(clr_ovf), .clr_unf(clr_unf), .head(head), .fill(fill_w),
    .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok), .ovf(overflow),
    .unf(underflow)
  );

  tfifo_frame #(.CNT_W(CNT_W), .TMR_W(TMR_W), .TICK_SH(TICK_SH)) u_frame (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .push_eof(push_word.eof),
    .pop_ok(pop_ok), .head_eof(head.eof), .access(push | pop_ok),
    .frm_en(frm_en), .tmr_en(tmr_en), .period(tmr_period), .fill(fill_w),
    .frame_count(frame_count), .frame_ready(frame_ready), .frame_req(frame_req)
  );

  tfifo_alarm #(.DEPTH(DEPTH), .CNT_W(CNT_W), .GRAN_W(GRAN_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .fill(fill_w), .level(alarm_level), .gran(gran),
    .frm_en(frm_en), .alarm(alarm)
  );

  assign fill     = fill_w;
  assign pop_data = head.data;
  assign pop_ctl  = head.ctl;
  assign pop_eof  = head.eof;
endmodule

// File: tb/test_tagged_tx_fifo.sv
`timescale 1ns/1ps
module test_tagged_tx_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pop;
  logic [31:0] pop_data;
  logic        pop_ctl, pop_eof, empty;
  logic [6:0]  fill, frame_count;
  logic        frame_ready, frame_req, alarm, overflow, underflow;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  logic [33:0] sb[$];

  localparam logic [31:0] C_CTL = 32'h4000_0000;
  localparam logic [31:0] C_EOF = 32'h2000_0000;
  localparam logic [31:0] C_TMR = 32'h1000_0000;
  localparam logic [31:0] C_FRM = 32'h0800_0000;

  tagged_tx_fifo i_tagged_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .pop(pop), .pop_data(pop_data), .pop_ctl(pop_ctl),
    .pop_eof(pop_eof), .empty(empty), .fill(fill), .frame_count(frame_count),
    .frame_ready(frame_ready), .frame_req(frame_req), .alarm(alarm),
    .overflow(overflow), .underflow(underflow)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      finish_run();
    end
  end

  // monitor: compare every popped word with the scoreboard
  always @(negedge clk) begin
    if (rst_n && pop && !empty) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R1 pop with no expected word act=%0h exp=none", {pop_ctl, pop_eof, pop_data});
      end else begin
        logic [33:0] e;
        e = sb.pop_front();
        if ({pop_ctl, pop_eof, pop_data} !== e) begin
          bad++;
          $display("FAIL R1 popped word act=%0h exp=%0h", {pop_ctl, pop_eof, pop_data}, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic ectl, input logic eeof);
    if (sb.size() < 64) sb.push_back({ectl, eeof, d});
    reg_wr(2'd2, d);
  endtask

  task automatic push_n(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) push(base + 32'(i), 1'b0, 1'b0);
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      pop = 1'b1;
      @(posedge clk); #1;
      pop = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; pop = 1'b0;
    #23;
    // R10: reset state
    chk("R10 empty", empty, 1);
    chk("R10 fill", fill, 0);
    chk("R10 frame_count", frame_count, 0);
    chk("R10 flags", {frame_ready, frame_req, alarm, overflow, underflow}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(2);

    // R1: plain ordering
    push_n(5, 32'hA000_0000);
    chk("R1 fill after 5", fill, 5);
    pop_n(5);
    chk("R1 drained", empty, 1);

    // R2: one-shot control tag
    reg_wr(2'd0, C_CTL);
    push(32'h1111_0001, 1'b1, 1'b0);
    push(32'h1111_0002, 1'b0, 1'b0);
    pop_n(2);

    // R3/R4: end-of-frame tag in frame mode, then armed without frame mode
    reg_wr(2'd0, C_FRM | C_EOF);
    push(32'h2222_0001, 1'b0, 1'b1);
    chk("R4 count after eof push", frame_count, 1);
    chk("R4 ready in frame mode", frame_ready, 1);
    reg_wr(2'd0, C_EOF);
    push(32'h2222_0002, 1'b0, 1'b0);
    chk("R3 eof ignored without frame mode", frame_count, 1);
    chk("R4 ready needs frame mode", frame_ready, 0);
    pop_n(1);
    chk("R4 count after eof pop", frame_count, 0);
    pop_n(1);

    // R4: two frames
    reg_wr(2'd0, C_FRM);
    push(32'h3333_0001, 1'b0, 1'b0);
    reg_wr(2'd0, C_FRM | C_EOF);
    push(32'h3333_0002, 1'b0, 1'b1);
    reg_wr(2'd0, C_FRM | C_EOF);
    push(32'h3333_0003, 1'b0, 1'b1);
    chk("R4 two frames", frame_count, 2);
    pop_n(2);
    chk("R4 one frame left", frame_count, 1);
    pop_n(1);
    chk("R4 none left", frame_ready, 0);

    // R7 + R5: hysteresis outside frame mode, level 8, G=1 (clear below 4)
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd1, 32'h0000_0108);
    idle(1);
    chk("R7 alarm at free 64", alarm, 1);
    push_n(60, 32'h4000_0000);
    idle(1);
    chk("R7 alarm held at free 4", alarm, 1);
    push_n(1, 32'h4100_0000);
    idle(1);
    chk("R7 alarm clears at free 3", alarm, 0);
    push_n(3, 32'h4200_0000);
    chk("R5 full", fill, 64);
    push(32'hDEAD_BEEF, 1'b0, 1'b0);
    chk("R5 fill after drop", fill, 64);
    chk("R5 overflow flag", overflow, 1);
    reg_wr(2'd3, 32'h1);
    chk("R5 overflow cleared", overflow, 0);
    pop_n(4);
    idle(1);
    chk("R7 alarm stays low at free 4", alarm, 0);
    pop_n(3);
    idle(1);
    chk("R7 alarm low at free 7", alarm, 0);
    pop_n(1);
    idle(1);
    chk("R7 alarm sets at free 8", alarm, 1);
    pop_n(56);
    chk("R5 drained", empty, 1);

    // R6: underflow
    pop_n(1);
    chk("R6 underflow flag", underflow, 1);
    chk("R6 fill stays 0", fill, 0);
    reg_wr(2'd3, 32'h2);
    chk("R6 underflow cleared", underflow, 0);

    // R8: frame mode alarm has no hysteresis
    reg_wr(2'd0, C_FRM);
    push_n(56, 32'h5000_0000);
    idle(1);
    chk("R8 alarm at free 8", alarm, 1);
    push_n(1, 32'h5100_0000);
    idle(1);
    chk("R8 alarm drops at free 7", alarm, 0);
    pop_n(1);
    idle(1);
    chk("R8 alarm back at free 8", alarm, 1);
    pop_n(56);

    // R9: timer mode, N=1 -> 64-cycle period
    reg_wr(2'd0, C_FRM | C_TMR | 32'd1);
    begin
      int hits = 0;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        if (frame_req) hits++;
      end
      chk("R9 no request without frame", hits, 0);
    end
    @(posedge clk); #1;
    reg_wr(2'd0, C_FRM | C_TMR | C_EOF | 32'd1);
    push(32'h6000_0001, 1'b0, 1'b1);
    chk("R9 no level request in timer mode", frame_req, 0);
    begin
      int t1 = -1, t2 = -1, wide = 0;
      bit prev = 0;
      for (int i = 0; i < 140; i++) begin
        @(negedge clk);
        if (frame_req && prev) wide++;
        if (frame_req) begin
          if (t1 < 0) t1 = i;
          else if (t2 < 0) t2 = i;
        end
        prev = frame_req;
      end
      chk("R9 first pulse", t1, 64);
      chk("R9 pulse spacing", t2 - t1, 64);
      chk("R9 pulse width", wide, 0);
    end
    @(posedge clk); #1;
    reg_wr(2'd0, C_FRM);
    chk("R9 level request without timer", frame_req, 1);
    pop_n(1);
    chk("R9 request gone after pop", frame_req, 0);
    idle(2);
    chk("R1 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule